// File: doc/BRIEF.md
# Floating-Point Compare Condition Unit

This block compares two IEEE-754 operands and produces the condition flags that conditional branches on the floating-point path test. A precision select picks one of two formats. In single mode, each operand is the low 32 bits of its input word. In double mode, it is the full 64-bit word. Each operand is first sorted into one of these classes: signalling NaN, quiet NaN, zero or ordinary value. Any operand with a zero exponent field counts as zero, so denormals are flushed before the comparison.

Each compare produces a fresh result. The condition field and the invalid cause are both replaced, so a flag from an earlier compare never carries into the next one. A signalling NaN can end in one of two ways. If the invalid enable is set, the invalid cause is raised and the condition field is left at zero. If it is clear, the unordered code is written. The result is registered, and `done` pulses one cycle after the strobe.

The controller has two states. In `ST_IDLE` no result is being reported. In `ST_REPORT` the result captured at the previous edge is on the outputs. The transitions are:
- IDLE to REPORT on a strobe.
- REPORT to REPORT on a back-to-back strobe.
- REPORT to IDLE when the strobe is low.
- IDLE to IDLE when the strobe is low.

Top module: `fp_cmp_unit`

## Requirements
- R1: After reset, `cond_code` is 4'b0000, `inv_cause` is 0 and `done` is 0.
- R2: `done` is high in the cycle after each cycle with `in_valid` high, and low after each cycle with `in_valid` low. Back-to-back strobes give one result per cycle.
- R3: `cond_code` is one-hot, with bit 3 = unordered, bit 2 = less, bit 1 = greater and bit 0 = equal. Exactly one bit is set whenever `inv_cause` is 0.
- R4: If either operand is a signalling NaN (maximum exponent, nonzero fraction, fraction MSB 0) and `inv_en` is 1, then `inv_cause` is 1 and `cond_code` is 4'b0000.
- R5: If either operand is a signalling NaN and `inv_en` is 0, then `cond_code` is 4'b1000 and `inv_cause` is 0.
- R6: If either operand is a quiet NaN (maximum exponent, fraction MSB 1) and neither is signalling, then `cond_code` is 4'b1000 and `inv_cause` is 0, whatever `inv_en` is.
- R7: Ordered operands give less (4'b0100) when A < B and greater (4'b0010) when A > B. This includes infinities and negative values.
- R8: Equal operands give 4'b0001, and +0 compares equal to -0.
- R9: An operand with a zero exponent field is treated as zero. A denormal therefore equals zero, and two different denormals are equal.
- R10: With `dbl_sel` = 0, only bits 31:0 of each operand are used and bits 63:32 have no effect. With `dbl_sel` = 1, all 64 bits are compared as a double.
- R11: While `in_valid` is low, `cond_code` and `inv_cause` keep their last values.
- R12: A new compare replaces the previous result, so a prior invalid cause is cleared by the next non-invalid compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Compare strobe |
| dbl_sel | input | 1 | 1 = 64-bit double operands, 0 = 32-bit single operands in the low word |
| inv_en | input | 1 | Invalid-exception enable |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand |
| cond_code | output | 4 | One-hot condition: [3] unordered, [2] less, [1] greater, [0] equal |
| inv_cause | output | 1 | Invalid cause raised by a signalling NaN |
| done | output | 1 | Result-valid pulse |

## Verification
Every result is due exactly one cycle after its strobe. Inputs are driven on the falling edge. `cond_code`, `inv_cause` and `done` are registered at the next rising edge, and the outputs are sampled at the falling edge after that.

The driver pushes one expected item per strobe into a queue. The monitor pops one item on each falling edge where `done` is high. A `done` with an empty queue is reported as a failure, and so is an item still left in the queue at the end. The hold and reset checks sample the ports on falling edges where no strobe was given in the previous cycle.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
    localparam int DP_EXP  = 11;
    localparam int DP_FRAC = 52;
    localparam int SP_EXP  = 8;
    localparam int SP_FRAC = 23;
    localparam int WORD_W  = DP_EXP + DP_FRAC + 1;
    localparam int MAG_W   = DP_EXP + DP_FRAC;
    localparam int CC_W    = 4;

    localparam logic [CC_W-1:0] CC_UNORD = 4'b1000;
    localparam logic [CC_W-1:0] CC_LESS  = 4'b0100;
    localparam logic [CC_W-1:0] CC_GREAT = 4'b0010;
    localparam logic [CC_W-1:0] CC_EQUAL = 4'b0001;

    typedef struct packed {
        logic             snan;
        logic             qnan;
        logic             zero;
        logic             sign;
        logic [MAG_W-1:0] mag;
    } fp_info_t;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_REPORT = 1'b1
    } cmp_state_t;
endpackage

// File: rtl/fp_unpack.sv
module fp_unpack
    import fcmp_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] raw,
    output fp_info_t              info
);
    localparam int TOP = EXP_W + FRAC_W;

    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;
    logic              exp_max;
    logic              exp_nil;

    assign exp_f   = raw[TOP-1:FRAC_W];
    assign frac_f  = raw[FRAC_W-1:0];
    assign exp_max = &exp_f;
    assign exp_nil = ~|exp_f;

    always_comb begin
        info.sign = raw[TOP];
        info.qnan = exp_max & frac_f[FRAC_W-1];
        info.snan = exp_max & ~frac_f[FRAC_W-1] & (|frac_f);
        // denormals are flushed: any zero exponent counts as zero
        info.zero = exp_nil;
        info.mag  = exp_nil ? '0 : MAG_W'({exp_f, frac_f});
    end
endmodule

// File: rtl/fp_order.sv
module fp_order
    import fcmp_pkg::*;
(
    input  fp_info_t        a,
    input  fp_info_t        b,
    input  logic            inv_en,
    output logic [CC_W-1:0] code,
    output logic            inv
);
    logic mag_lt;
    logic mag_eq;

    assign mag_lt = a.mag < b.mag;
    assign mag_eq = a.mag == b.mag;

    always_comb begin
        code = '0;
        inv  = 1'b0;
        if (a.snan || b.snan) begin
            if (inv_en) inv  = 1'b1;
            else        code = CC_UNORD;
        end else if (a.qnan || b.qnan) begin
            code = CC_UNORD;
        end else if (a.zero && b.zero) begin
            code = CC_EQUAL;
        end else if (a.sign != b.sign) begin
            code = a.sign ? CC_LESS : CC_GREAT;
        end else if (mag_eq) begin
            code = CC_EQUAL;
        end else if (mag_lt ^ a.sign) begin
            code = CC_LESS;
        end else begin
            code = CC_GREAT;
        end
    end
endmodule

// File: rtl/fp_cmp_unit.sv
module fp_cmp_unit
    import fcmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              dbl_sel,
    input  logic              inv_en,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    output logic [CC_W-1:0]   cond_code,
    output logic              inv_cause,
    output logic              done
);
    localparam int N_OPS = 2;
    localparam int SP_W  = SP_EXP + SP_FRAC + 1;

    logic [WORD_W-1:0] opnd [N_OPS];
    fp_info_t          info [N_OPS];
    logic [CC_W-1:0]   code_nx;
    logic              inv_nx;
    cmp_state_t        state, state_nx;

    assign opnd[0] = op_a;
    assign opnd[1] = op_b;

    for (genvar i = 0; i < N_OPS; i++) begin : g_unpack
        fp_info_t sp_info, dp_info;

        fp_unpack #(.EXP_W(SP_EXP), .FRAC_W(SP_FRAC)) u_sp (
            .raw  (opnd[i][SP_W-1:0]),
            .info (sp_info)
        );
        fp_unpack #(.EXP_W(DP_EXP), .FRAC_W(DP_FRAC)) u_dp (
            .raw  (opnd[i]),
            .info (dp_info)
        );

        assign info[i] = dbl_sel ? dp_info : sp_info;
    end

    fp_order u_order (
        .a      (info[0]),
        .b      (info[1]),
        .inv_en (inv_en),
        .code   (code_nx),
        .inv    (inv_nx)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   state_nx = in_valid ? ST_REPORT : ST_IDLE;
            ST_REPORT: state_nx = in_valid ? ST_REPORT : ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cond_code <= '0;
            inv_cause <= 1'b0;
        end else if (in_valid) begin
            cond_code <= code_nx;
            inv_cause <= inv_nx;
        end
    end

    assign done = (state == ST_REPORT);
endmodule

// File: rtl/fp_cmp_unit_chk.sv
module fp_cmp_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       inv_en,
    input logic [3:0] cond_code,
    input logic       inv_cause,
    input logic       done
);
    a_r2_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> done);
    a_r2_no_stray_done: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !done);
    a_r3_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !inv_cause) |-> ($countones(cond_code) == 1));
    a_r4_cause_clears_code: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !inv_en) |=> !inv_cause);
    a_r4_cause_empty_code: assert property (@(posedge clk) disable iff (!rst_n)
        inv_cause |-> (cond_code == 4'b0000));
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(cond_code) && $stable(inv_cause)));
endmodule

bind fp_cmp_unit fp_cmp_unit_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .inv_en    (inv_en),
    .cond_code (cond_code),
    .inv_cause (inv_cause),
    .done      (done)
);

// File: tb/tb_fp_cmp_unit.sv
module tb_fp_cmp_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        dbl_sel = 1'b0;
    logic        inv_en = 1'b0;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic [3:0]  cond_code;
    logic        inv_cause;
    logic        done;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    typedef struct {
        logic [3:0] code;
        logic       cause;
        string      rq;
    } exp_t;
    exp_t sb[$];

    localparam logic [3:0] U = 4'b1000, L = 4'b0100, G = 4'b0010, E = 4'b0001;

    always #10 clk = ~clk;

    fp_cmp_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .dbl_sel(dbl_sel),
        .inv_en(inv_en), .op_a(op_a), .op_b(op_b),
        .cond_code(cond_code), .inv_cause(inv_cause), .done(done)
    );

    task automatic check(input bit ok, input string rq, input logic [4:0] act, input logic [4:0] expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual {code,cause}=%b expected %b", rq, act, expv);
        end
    endtask

    task automatic cmp(input logic [63:0] a, input logic [63:0] b, input logic dbl,
                       input logic en, input logic [3:0] ec, input logic ecause, input string rq);
        exp_t it;
        @(negedge clk);
        in_valid = 1'b1; op_a = a; op_b = b; dbl_sel = dbl; inv_en = en;
        it.code = ec; it.cause = ecause; it.rq = rq;
        sb.push_back(it);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        in_valid = 1'b0;
        op_a = 64'h7FF0_0000_0000_0001; op_b = '1; inv_en = 1'b1;
        repeat (n) @(negedge clk);
    endtask

    // monitor: pops one expected item per done pulse
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb.size() == 0) begin
                check(1'b0, "R2 unexpected done", {cond_code, inv_cause}, 5'b0);
            end else begin
                exp_t it;
                it = sb.pop_front();
                check({cond_code, inv_cause} === {it.code, it.cause}, it.rq,
                      {cond_code, inv_cause}, {it.code, it.cause});
            end
        end
    end

    initial begin
        repeat (10000) @(posedge clk);
        if (!finished) begin
            n_fail++; n_tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(cond_code == 4'b0 && !inv_cause && !done, "R1 reset state",
              {cond_code, inv_cause}, 5'b0);

        // single precision ordering (R7, R3)
        cmp(64'h3F80_0000, 64'h4000_0000, 0, 0, L, 0, "R7 1.0<2.0 single");
        cmp(64'h4000_0000, 64'h3F80_0000, 0, 0, G, 0, "R7 2.0>1.0 single");
        cmp(64'hBF80_0000, 64'h3F80_0000, 0, 0, L, 0, "R7 -1<1 single");
        cmp(64'hC000_0000, 64'hBF80_0000, 0, 0, L, 0, "R7 -2<-1 single");
        cmp(64'h7F80_0000, 64'h7F7F_FFFF, 0, 0, G, 0, "R7 +inf>max single");
        cmp(64'hFF80_0000, 64'hFF7F_FFFF, 0, 0, L, 0, "R7 -inf<-max single");
        cmp(64'h3F80_0000, 64'h3F80_0000, 0, 0, E, 0, "R3 R8 equal single");
        // R8 signed zeros
        cmp(64'h8000_0000, 64'h0000_0000, 0, 0, E, 0, "R8 -0==+0 single");
        cmp(64'h8000_0000_0000_0000, 64'h0, 1, 0, E, 0, "R8 -0==+0 double");
        // R9 denormal flush
        cmp(64'h0000_0001, 64'h0000_0000, 0, 0, E, 0, "R9 denorm==0");
        cmp(64'h8000_0005, 64'h0040_0000, 0, 0, E, 0, "R9 two denorms equal");
        cmp(64'h0000_0001, 64'h0080_0000, 0, 0, L, 0, "R9 denorm<min normal");
        // NaNs (R4 R5 R6)
        cmp(64'h7F80_0001, 64'h3F80_0000, 0, 1, 4'b0, 1, "R4 snan enabled");
        cmp(64'h3F80_0000, 64'h7F80_0001, 0, 0, U, 0, "R5 snan disabled");
        cmp(64'h7FC0_0000, 64'h3F80_0000, 0, 1, U, 0, "R6 qnan with enable");
        cmp(64'h3F80_0000, 64'hFFC0_0000, 0, 0, U, 0, "R6 qnan operand b");
        cmp(64'h7FF0_0000_0000_0001, 64'h0, 1, 1, 4'b0, 1, "R4 snan double");
        // R12 cause cleared by next compare
        cmp(64'h3F80_0000, 64'h3F80_0000, 0, 1, E, 0, "R12 cause cleared");
        // R10 precision select
        cmp(64'hFFFF_FFFF_3F80_0000, 64'h0000_0000_4000_0000, 0, 1, L, 0, "R10 upper bits ignored");
        cmp(64'h3FF0_0000_0000_0000, 64'h3FF0_0000_0000_0001, 1, 0, L, 0, "R10 double full width");
        cmp(64'h3FF0_0000_0000_0000, 64'h3FF0_0000_0000_0001, 0, 0, E, 0, "R10 same words as single");
        cmp(64'hC000_0000_0000_0000, 64'h3FF0_0000_0000_0000, 1, 0, L, 0, "R7 -2<1 double");
        cmp(64'h7FF8_0000_0000_0000, 64'h0, 1, 0, U, 0, "R6 qnan double");
        idle(3);
        // R11 hold while idle (inputs changed to a signalling NaN meanwhile)
        check(cond_code == U && !inv_cause && !done, "R11 hold while idle",
              {cond_code, inv_cause}, {U, 1'b0});
        // R2 single strobe: done one cycle later, then low
        cmp(64'h4000_0000, 64'h3F80_0000, 0, 0, G, 0, "R2 single strobe");
        @(negedge clk);
        in_valid = 1'b0;
        check(done == 1'b1, "R2 done after strobe", {4'b0, done}, 5'b1);
        @(negedge clk);
        check(done == 1'b0, "R2 done drops", {4'b0, done}, 5'b0);
        check(cond_code == G, "R11 hold after result", {cond_code, inv_cause}, {G, 1'b0});
        repeat (2) @(negedge clk);
        check(sb.size() == 0, "R2 every strobe answered", 5'(sb.size()), 5'b0);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule